// File: doc/BRIEF.md
# Station-side carrier-sense channel access sequencer

The block runs one station's medium access procedure for a wireless LAN. A frame owner presents a transmit request. The sequencer waits for the medium to stay quiet for a full inter-frame gap. If the medium becomes busy it defers, and after the medium clears it starts the gap over again. Once the gap has passed, it draws a random number of backoff slots and counts them down, but only while the medium is quiet. When the count reaches zero it tells the transmitter to send a request-to-send (RTS) frame. It then waits a bounded time for a clear-to-send (CTS) indication. After the CTS it strobes the start of the data frame and waits a bounded time for the acknowledgement.

A missing CTS or a missing acknowledgement counts as a failed attempt. After a failure the contention window doubles and the procedure starts again from the gap check. When the retry budget runs out, the transfer is abandoned. Each transfer ends with a single done pulse. A status flag beside that pulse tells success from failure. Frame contents, checksums and the radio are handled elsewhere. The block only sees the CTS and acknowledgement outcomes as one-cycle indications.

The request uses a valid/ready pair: `tx_req` is taken only in a cycle where `tx_ready` is high. `tx_ready` is high only while the sequencer is idle, and a request offered at any other time is dropped. The requester may hold `tx_req` until it sees `tx_ready`. The carrier-sense, CTS and acknowledgement inputs are plain level or pulse signals with no back-pressure.

Top module: `csma_access_ctrl`

## Requirements
- R1: `tx_ready` is 1 exactly while the sequencer is idle. A request is accepted on a clock edge where `tx_req` and `tx_ready` are both 1, and `tx_ready` is 0 in the following cycle.
- R2: After acceptance, the gap check needs `IFS_CYC` consecutive edges with `carrier_busy`=0. A busy edge during the gap moves the sequencer to a defer state. At the first quiet edge after that, the gap count restarts from zero.
- R3: At the end of the gap the backoff count is loaded with (LFSR value) AND (contention window). The LFSR is a 16-bit register loaded with `LFSR_SEED` at reset. It advances once per backoff draw: it shifts left by one, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10. The draw uses the value held before the shift.
- R4: The backoff count falls by one after each run of `SLOT_CYC` quiet edges. A busy edge freezes both the count and the position within the slot. The first quiet edge that finds the count at zero ends the backoff. `rts_start` is high in the cycle after that edge. With a draw B and K busy edges, this is `IFS_CYC + B*SLOT_CYC + 1 + K` cycles after the gap starts.
- R5: After `rts_start`, a CTS is accepted on any of the next `CTS_TO` edges. `data_start` is high in the cycle after the edge that sampled `cts_seen`=1. If no CTS arrives on those edges, the attempt fails on the last of them.
- R6: After `data_start`, an acknowledgement is accepted on any of the next `ACK_TO` edges. Accepting it gives `done`=1 and `done_ok`=1 in the following cycle. If no acknowledgement arrives, the attempt fails on the last of those edges. `done_ok` is never 1 without `done`.
- R7: The contention window starts at `CW_MIN`. Each failed attempt that leaves retries sets it to min(2*CW+1, `CW_MAX`), and the next gap check starts on the edge of the failure. The window returns to `CW_MIN` when a transfer ends, whether it succeeds or is abandoned.
- R8: A transfer makes at most `RETRY_LIMIT`+1 attempts. When the last attempt fails, `done`=1 with `done_ok`=0 in the following cycle, and the sequencer returns to idle.
- R9: `cts_seen` and `ack_seen` have no effect outside their waiting windows. `tx_req` has no effect while `tx_ready` is 0. No strobe or done pulse results from either.
- R10: While reset is low and just after it is released, `tx_ready`=1 and `rts_start`, `data_start`, `done` and `done_ok` are 0. At most one of `rts_start`, `data_start` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Transmit request (valid) |
| tx_ready | output | 1 | Request can be taken; high only when idle |
| carrier_busy | input | 1 | Carrier sense: 1 when the medium is occupied |
| cts_seen | input | 1 | One-cycle indication that a CTS frame arrived |
| ack_seen | input | 1 | One-cycle indication that an acknowledgement arrived |
| rts_start | output | 1 | One-cycle strobe: start sending the RTS frame |
| data_start | output | 1 | One-cycle strobe: start sending the data frame |
| done | output | 1 | One-cycle pulse: the transfer has ended |
| done_ok | output | 1 | With `done`: 1 for success, 0 for abandon |

## Verification
The bench builds the sequencer with a five-cycle gap, three-cycle slots, CTS and acknowledgement timeouts of six and seven cycles, a contention window from 3 to 15, and a retry limit of 3. With a window of 3 to 15, four failed attempts are enough to reach the cap and stay on it. That lets one abandoned transfer show doubling, saturation and the reset of the window, and a following clean transfer confirms the reset. The short gap and slot lengths keep every predicted strobe cycle small enough to compute exactly, including the cycles added by deferral and by a frozen backoff.

// File: rtl/csma_pkg.sv
package csma_pkg;

  localparam int RAND_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_GAP      = 3'd1,
    ST_DEFER    = 3'd2,
    ST_BACKOFF  = 3'd3,
    ST_WAIT_CTS = 3'd4,
    ST_WAIT_ACK = 3'd5
  } acc_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int              OUT_W = 10,
  parameter logic [15:0]     SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_W-1:0] value
);
  import csma_pkg::*;

  logic [RAND_W-1:0] q;
  logic              fb;

  // taps for x^16 + x^14 + x^13 + x^11 + 1
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= SEED;
    end else if (step) begin
      q <= {q[RAND_W-2:0], fb};
    end
  end

  assign value = q[OUT_W-1:0];

endmodule

// File: rtl/csma_cw.sv
module csma_cw #(
  parameter int CW_W   = 10,
  parameter int CW_MIN = 15,
  parameter int CW_MAX = 1023
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grow,
  input  logic            shrink,
  output logic [CW_W-1:0] cw
);
  localparam logic [CW_W-1:0] MIN_V = CW_W'(CW_MIN);
  localparam logic [CW_W:0]   MAX_W = (CW_W+1)'(CW_MAX);
  localparam logic [CW_W-1:0] MAX_V = CW_W'(CW_MAX);

  logic [CW_W:0] doubled;

  assign doubled = {cw, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cw <= MIN_V;
    end else if (shrink) begin
      cw <= MIN_V;
    end else if (grow) begin
      cw <= (doubled > MAX_W) ? MAX_V : doubled[CW_W-1:0];
    end
  end

endmodule

// File: rtl/csma_backoff.sv
module csma_backoff #(
  parameter int CNT_W    = 10,
  parameter int SLOT_CYC = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero,
  output logic [CNT_W-1:0] count
);
  localparam int              SLOT_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYC - 1);

  logic [SLOT_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      phase <= '0;
    end else if (load) begin
      count <= load_val;
      phase <= '0;
    end else if (run) begin
      if (phase == SLOT_LAST) begin
        phase <= '0;
        if (count != '0) count <= count - 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/csma_access_ctrl.sv
module csma_access_ctrl #(
  parameter int          IFS_CYC     = 34,
  parameter int          SLOT_CYC    = 9,
  parameter int          CTS_TO      = 44,
  parameter int          ACK_TO      = 44,
  parameter int          CW_MIN      = 15,
  parameter int          CW_MAX      = 1023,
  parameter int          RETRY_LIMIT = 6,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  output logic tx_ready,
  input  logic carrier_busy,
  input  logic cts_seen,
  input  logic ack_seen,
  output logic rts_start,
  output logic data_start,
  output logic done,
  output logic done_ok
);
  import csma_pkg::*;

  localparam int CW_W  = $clog2(CW_MAX + 1);
  localparam int TMR_W = $clog2(max3(IFS_CYC, CTS_TO, ACK_TO) + 1);
  localparam int RTY_W = $clog2(RETRY_LIMIT + 2);

  localparam logic [TMR_W-1:0] GAP_LAST = TMR_W'(IFS_CYC - 1);
  localparam logic [TMR_W-1:0] CTS_LAST = TMR_W'(CTS_TO - 1);
  localparam logic [TMR_W-1:0] ACK_LAST = TMR_W'(ACK_TO - 1);
  localparam logic [RTY_W-1:0] RTY_LAST = RTY_W'(RETRY_LIMIT);

  acc_state_t       st, st_nx;
  logic [TMR_W-1:0] tmr, tmr_nx;
  logic [RTY_W-1:0] retry, retry_nx;
  logic             rts_nx, data_nx, done_nx, ok_nx;
  logic             bo_load, bo_run, bo_zero, attempt_fail;
  logic             cw_grow, cw_shrink;
  logic [CW_W-1:0]  cw, rand_bits, draw;
  logic [CW_W-1:0]  bo_count;

  csma_lfsr #(.OUT_W(CW_W), .SEED(LFSR_SEED)) u_rand (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (bo_load),
    .value (rand_bits)
  );

  csma_cw #(.CW_W(CW_W), .CW_MIN(CW_MIN), .CW_MAX(CW_MAX)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .grow   (cw_grow),
    .shrink (cw_shrink),
    .cw     (cw)
  );

  assign draw   = rand_bits & cw;
  assign bo_run = (st == ST_BACKOFF) && !carrier_busy;

  csma_backoff #(.CNT_W(CW_W), .SLOT_CYC(SLOT_CYC)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bo_load),
    .load_val (draw),
    .run      (bo_run),
    .zero     (bo_zero),
    .count    (bo_count)
  );

  always_comb begin
    st_nx        = st;
    tmr_nx       = tmr;
    retry_nx     = retry;
    rts_nx       = 1'b0;
    data_nx      = 1'b0;
    done_nx      = 1'b0;
    ok_nx        = 1'b0;
    bo_load      = 1'b0;
    cw_grow      = 1'b0;
    cw_shrink    = 1'b0;
    attempt_fail = 1'b0;
    case (st)
      ST_IDLE: begin
        if (tx_req) begin
          st_nx    = ST_GAP;
          tmr_nx   = '0;
          retry_nx = '0;
        end
      end
      ST_GAP: begin
        if (carrier_busy) begin
          st_nx = ST_DEFER;
        end else if (tmr == GAP_LAST) begin
          st_nx   = ST_BACKOFF;
          bo_load = 1'b1;
        end else begin
          tmr_nx = tmr + 1'b1;
        end
      end
      ST_DEFER: begin
        if (!carrier_busy) begin
          st_nx  = ST_GAP;
          tmr_nx = '0;
        end
      end
      ST_BACKOFF: begin
        if (!carrier_busy && bo_zero) begin
          st_nx  = ST_WAIT_CTS;
          tmr_nx = '0;
          rts_nx = 1'b1;
        end
      end
      ST_WAIT_CTS: begin
        if (cts_seen) begin
          st_nx   = ST_WAIT_ACK;
          tmr_nx  = '0;
          data_nx = 1'b1;
        end else if (tmr == CTS_LAST) begin
          attempt_fail = 1'b1;
        end else begin
          tmr_nx = tmr + 1'b1;
        end
      end
      ST_WAIT_ACK: begin
        if (ack_seen) begin
          st_nx     = ST_IDLE;
          done_nx   = 1'b1;
          ok_nx     = 1'b1;
          cw_shrink = 1'b1;
        end else if (tmr == ACK_LAST) begin
          attempt_fail = 1'b1;
        end else begin
          tmr_nx = tmr + 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase

    if (attempt_fail) begin
      if (retry == RTY_LAST) begin
        st_nx     = ST_IDLE;
        done_nx   = 1'b1;
        cw_shrink = 1'b1;
      end else begin
        st_nx    = ST_GAP;
        tmr_nx   = '0;
        retry_nx = retry + 1'b1;
        cw_grow  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      tmr        <= '0;
      retry      <= '0;
      rts_start  <= 1'b0;
      data_start <= 1'b0;
      done       <= 1'b0;
      done_ok    <= 1'b0;
    end else begin
      st         <= st_nx;
      tmr        <= tmr_nx;
      retry      <= retry_nx;
      rts_start  <= rts_nx;
      data_start <= data_nx;
      done       <= done_nx;
      done_ok    <= ok_nx;
    end
  end

  assign tx_ready = (st == ST_IDLE);

endmodule

// File: rtl/csma_access_chk.sv
module csma_access_chk #(
  parameter int CW_W        = 10,
  parameter int RTY_W       = 3,
  parameter int CW_MIN      = 15,
  parameter int CW_MAX      = 1023,
  parameter int RETRY_LIMIT = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_req,
  input logic                 tx_ready,
  input logic                 carrier_busy,
  input logic                 cts_seen,
  input logic                 rts_start,
  input logic                 data_start,
  input logic                 done,
  input logic                 done_ok,
  input csma_pkg::acc_state_t st,
  input logic [CW_W-1:0]      bo_count,
  input logic [CW_W-1:0]      cw,
  input logic [RTY_W-1:0]     retry
);
  import csma_pkg::*;

  localparam logic [CW_W-1:0]  MIN_V = CW_W'(CW_MIN);
  localparam logic [CW_W-1:0]  MAX_V = CW_W'(CW_MAX);
  localparam logic [RTY_W-1:0] RTY_V = RTY_W'(RETRY_LIMIT);

  a_r1_strobe_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_start || data_start) |-> !tx_ready);

  a_r1_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_ready) |=> !tx_ready);

  a_r2_busy_gap_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && carrier_busy) |=> (st == ST_DEFER));

  a_r4_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BACKOFF && carrier_busy) |=> ($stable(bo_count) && !rts_start));

  a_r5_data_follows_cts: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> $past(cts_seen));

  a_r6_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> done);

  a_r7_cw_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (cw >= MIN_V) && (cw <= MAX_V));

  a_r8_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= RTY_V);

  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rts_start, data_start, done}));

endmodule

bind csma_access_ctrl csma_access_chk #(
  .CW_W(CW_W), .RTY_W(RTY_W), .CW_MIN(CW_MIN), .CW_MAX(CW_MAX), .RETRY_LIMIT(RETRY_LIMIT)
) u_access_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_req       (tx_req),
  .tx_ready     (tx_ready),
  .carrier_busy (carrier_busy),
  .cts_seen     (cts_seen),
  .rts_start    (rts_start),
  .data_start   (data_start),
  .done         (done),
  .done_ok      (done_ok),
  .st           (st),
  .bo_count     (bo_count),
  .cw           (cw),
  .retry        (retry)
);

// File: tb/test_csma_access_ctrl.sv
`timescale 1ns/1ps
module test_csma_access_ctrl;

  localparam int          IFS   = 5;
  localparam int          SLOT  = 3;
  localparam int          CTO   = 6;
  localparam int          ATO   = 7;
  localparam int          CWMIN = 3;
  localparam int          CWMAX = 15;
  localparam int          RETRY = 3;
  localparam logic [15:0] SEED  = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0, carrier_busy = 1'b0, cts_seen = 1'b0, ack_seen = 1'b0;
  logic tx_ready, rts_start, data_start, done, done_ok;

  always #4 clk = ~clk;

  csma_access_ctrl #(
    .IFS_CYC(IFS), .SLOT_CYC(SLOT), .CTS_TO(CTO), .ACK_TO(ATO),
    .CW_MIN(CWMIN), .CW_MAX(CWMAX), .RETRY_LIMIT(RETRY), .LFSR_SEED(SEED)
  ) i_csma_access_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_ready(tx_ready),
    .carrier_busy(carrier_busy), .cts_seen(cts_seen), .ack_seen(ack_seen),
    .rts_start(rts_start), .data_start(data_start), .done(done), .done_ok(done_ok)
  );

  typedef struct {
    int kind;   // 0 rts, 1 data, 2 done
    int cyc;
    bit ok;
    int req;
  } ev_t;

  ev_t exp_q[$];
  int  cyc = 0;
  int  nchk = 0;
  int  nerr = 0;
  int  obs = 0;
  bit  finished = 1'b0;

  logic [15:0] m_rand = SEED;
  int          m_cw = CWMIN;
  int          plan_cts[0:7];
  int          plan_ack[0:7];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit cond, input string req, input int act, input int expv, input string what);
    nchk++;
    if (!cond) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] rand_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic push(input int kind, input int c, input bit okv, input int req);
    ev_t e;
    e.kind = kind; e.cyc = c; e.ok = okv; e.req = req;
    exp_q.push_back(e);
  endtask

  // wait so that what is driven next is sampled on edge c
  task automatic at_sample(input int c);
    while (cyc < c - 1) @(negedge clk);
  endtask

  task automatic match(input int kind, input bit okv);
    ev_t e;
    obs++;
    nchk++;
    if (exp_q.size() == 0) begin
      nerr++;
      $display("FAIL R9 unexpected event: actual kind %0d at cycle %0d expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.cyc != cyc || e.ok != okv) begin
        nerr++;
        $display("FAIL R%0d event kind/cycle/ok: actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 e.req, kind, cyc, okv, e.kind, e.cyc, e.ok);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rts_start)  match(0, 1'b0);
      if (data_start) match(1, 1'b0);
      if (done)       match(2, done_ok);
      if (done_ok && !done) begin
        nchk++; nerr++;
        $display("FAIL R6 done_ok without done: actual 1 expected 0");
      end
    end
  end

  task automatic set_plan(input int c0, input int a0, input int c1, input int a1,
                          input int c2, input int a2, input int c3, input int a3);
    plan_cts[0] = c0; plan_ack[0] = a0; plan_cts[1] = c1; plan_ack[1] = a1;
    plan_cts[2] = c2; plan_ack[2] = a2; plan_cts[3] = c3; plan_ack[3] = a3;
  endtask

  // driver: one transfer, expected events pushed ahead of time
  task automatic xfer(input int tag, input int gap_j, input int gap_k, input int bo_k, input bit mid_req);
    int p, start, b, r, d, f, fin, extra;
    while (!tx_ready) @(negedge clk);
    p = cyc + 1;
    tx_req = 1'b1;
    at_sample(p + 1);
    tx_req = 1'b0;
    check(tx_ready == 1'b0, "R1", tx_ready, 0, "ready after accept");
    start = p;
    if (gap_k > 0) begin
      at_sample(p + 1 + gap_j);
      carrier_busy = 1'b1;
      at_sample(p + 1 + gap_j + gap_k);
      carrier_busy = 1'b0;
      start = p + 1 + gap_j + gap_k;
    end
    if (mid_req) begin
      at_sample(p + 2);
      check(tx_ready == 1'b0, "R1", tx_ready, 0, "ready while busy with transfer");
      tx_req = 1'b1;   // R9: must be dropped
      at_sample(p + 3);
      tx_req = 1'b0;
    end
    for (int a = 0; a <= RETRY; a++) begin
      b = int'(m_rand) & m_cw;
      m_rand = rand_next(m_rand);
      extra = (a == 0) ? bo_k : 0;
      r = start + IFS + b * SLOT + 1 + extra;
      push(0, r, 1'b0, (a == 0) ? tag : 7);
      if (extra > 0) begin
        at_sample(start + IFS + 1);
        carrier_busy = 1'b1;
        at_sample(start + IFS + 1 + extra);
        carrier_busy = 1'b0;
      end
      if (plan_cts[a] > 0) begin
        d = r + plan_cts[a];
        push(1, d, 1'b0, 5);
        at_sample(d);
        cts_seen = 1'b1;
        at_sample(d + 1);
        cts_seen = 1'b0;
        if (plan_ack[a] > 0) begin
          fin = d + plan_ack[a];
          push(2, fin, 1'b1, 6);
          at_sample(fin);
          ack_seen = 1'b1;
          at_sample(fin + 1);
          ack_seen = 1'b0;
          m_cw = CWMIN;
          at_sample(fin + 2);
          return;
        end
        f = d + ATO;
      end else begin
        f = r + CTO;
      end
      if (a == RETRY) begin
        push(2, f, 1'b0, 8);
        m_cw = CWMIN;
        at_sample(f + 2);
        return;
      end
      m_cw = (m_cw * 2 + 1 > CWMAX) ? CWMAX : m_cw * 2 + 1;
      start = f;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int o;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(tx_ready == 1'b1, "R10", tx_ready, 1, "ready in reset");
    check(rts_start == 1'b0, "R10", rts_start, 0, "rts in reset");
    check(data_start == 1'b0, "R10", data_start, 0, "data in reset");
    check(done == 1'b0 && done_ok == 1'b0, "R10", done, 0, "done in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_ready == 1'b1, "R10", tx_ready, 1, "ready after reset");

    // R9: stray indications while idle
    o = obs;
    cts_seen = 1'b1; ack_seen = 1'b1; carrier_busy = 1'b1;
    repeat (3) @(negedge clk);
    cts_seen = 1'b0; ack_seen = 1'b0; carrier_busy = 1'b0;
    repeat (6) @(negedge clk);
    check(obs == o, "R9", obs - o, 0, "events from idle stray inputs");
    check(tx_ready == 1'b1, "R9", tx_ready, 1, "ready after stray inputs");

    // R3: clean transfer
    set_plan(2, 3, 0, 0, 0, 0, 0, 0);
    xfer(3, 0, 0, 0, 1'b0);
    // R2: busy inside the gap, then defer
    set_plan(1, 1, 0, 0, 0, 0, 0, 0);
    xfer(2, 2, 4, 0, 1'b0);
    // R4: busy during backoff freezes the count
    set_plan(3, 2, 0, 0, 0, 0, 0, 0);
    xfer(4, 0, 0, 5, 1'b0);
    // R5 and R7: no CTS on first attempt, success on second
    set_plan(0, 0, 3, 2, 0, 0, 0, 0);
    xfer(5, 0, 0, 0, 1'b0);
    // R6 and R7: missing ACK once, then success at the window edge
    set_plan(2, 0, CTO, ATO, 0, 0, 0, 0);
    xfer(6, 0, 0, 0, 1'b0);
    // R8: every attempt fails, window reaches cap, then abandon
    set_plan(0, 0, 0, 0, 0, 0, 0, 0);
    xfer(8, 0, 0, 0, 1'b0);
    // R7: window back at minimum after the abandon
    set_plan(1, 2, 0, 0, 0, 0, 0, 0);
    xfer(7, 0, 0, 0, 1'b0);
    // R9: request during a transfer is dropped
    set_plan(2, 2, 0, 0, 0, 0, 0, 0);
    xfer(1, 0, 0, 0, 1'b1);
    o = obs;
    repeat (80) @(negedge clk);
    check(obs == o, "R9", obs - o, 0, "events after dropped request");
    check(tx_ready == 1'b1, "R9", tx_ready, 1, "idle after dropped request");
    check(exp_q.size() == 0, "R4", exp_q.size(), 0, "expected events left");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule